// File: doc/BRIEF.md
# Next-PC Generator with One Delay Slot

This block produces the fetch address for a single-issue core whose control transfers take effect one instruction late. Each cycle the decoder presents the control-transfer kind of the instruction at the current PC, together with its 16-bit branch offset, its 26-bit jump target field, the two source register values and a register-held jump address. The block decides whether the transfer is taken and computes where it goes. The instruction right after the transfer, the delay slot, is always fetched and executed. The redirect is applied to the fetch that follows that slot.

For the linking kinds, the block also reports a return address equal to the transfer's PC plus 8, together with a write enable for the link register. Suppose a taken transfer has another transfer in its delay slot. The block does not support that case, so it raises an error flag and drops the second transfer. A stall input freezes all sequencing state.

Top module: `npc_unit`

## Requirements
- R1: While rst_ni is low, pc_o equals the START_PC parameter (default 0x0000_1000), and no redirect is pending. In the first cycle after release, link_we_o and err_o are low for a non-transfer kind.
- R2: When not stalled and with no redirect pending, pc_o in the next cycle is the current pc_o plus 4, whatever kind is presented.
- R3: While stall_i is high, pc_o and any pending redirect hold, and link_we_o and err_o stay low.
- R4: A taken conditional branch at address P makes pc_o read P+4 in the next cycle and then P+4 plus the sign-extended offset shifted left by 2. A pending redirect survives stalled cycles spent in the delay slot.
- R5: Kind code 1 is taken when rs_val_i equals rt_val_i. Kind code 2 is taken when they differ.
- R6: Kind codes 3, 4, 5 and 6 are taken when rs_val_i, as a signed value, is at most zero, above zero, below zero, and at least zero, respectively.
- R7: Kind codes 9 (jump) and 10 (jump with link) are always taken. Their target is {P[31:28], jmp_tgt_i, 2'b00}, where P is the address of the jump.
- R8: Kind code 11 is always taken and targets jr_addr_i.
- R9: Kind codes 7 and 10 and 8 assert link_we_o in the cycle they are presented, taken or not, with link_o equal to pc_o plus 8. Codes 7 and 8 branch as codes 5 and 6 do.
- R10: A branch that is not taken leaves the sequence at plus 4 for both the slot and the instruction after it.
- R11: A transfer kind (codes 1 to 11) presented in the delay slot of a taken transfer raises err_o in that cycle. It writes no link and causes no redirect: the fetch goes to the first target and then continues at plus 4.
- R12: Kind codes 0 and 12 to 15 are not transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold all sequencing state this cycle |
| xfer_kind_i | input | 4 | Control-transfer kind of the instruction at pc_o |
| br_off_i | input | 16 | Branch word offset |
| jmp_tgt_i | input | 26 | Jump target field |
| rs_val_i | input | 32 | First compared register value |
| rt_val_i | input | 32 | Second compared register value |
| jr_addr_i | input | 32 | Register-held jump address |
| pc_o | output | 32 | Current fetch address |
| link_o | output | 32 | Return address (pc_o + 8) |
| link_we_o | output | 1 | Write link_o to the link register |
| err_o | output | 1 | Transfer found in a taken transfer's delay slot |

## Verification
link_we_o, link_o and err_o follow the kind presented in the same cycle. pc_o is registered, so it shows the plus-4 step one clock edge after an instruction is presented. A taken redirect reaches pc_o two unstalled edges later, because the delay slot sits in between. The driver presents each instruction just after a falling edge and queues what that cycle must show. The monitor checks the queue 1 ns after that same falling edge. By then the combinational outputs have settled and pc_o reflects every earlier edge. Each expected PC therefore lands on the exact cycle where the slot or the redirect must appear.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    XK_NONE     = 4'd0,
    XK_BR_EQ    = 4'd1,
    XK_BR_NE    = 4'd2,
    XK_BR_LEZ   = 4'd3,
    XK_BR_GTZ   = 4'd4,
    XK_BR_LTZ   = 4'd5,
    XK_BR_GEZ   = 4'd6,
    XK_BR_LTZ_L = 4'd7,
    XK_BR_GEZ_L = 4'd8,
    XK_JMP      = 4'd9,
    XK_JMP_L    = 4'd10,
    XK_JMP_REG  = 4'd11
  } xfer_kind_e;

  function automatic logic is_xfer(input logic [3:0] k);
    return (k >= 4'd1) && (k <= 4'd11);
  endfunction

  function automatic logic is_link(input logic [3:0] k);
    return (k == 4'd7) || (k == 4'd8) || (k == 4'd10);
  endfunction
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      kind_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            taken_o
);
  logic eq, neg, zero;
  assign eq   = (rs_i == rt_i);
  assign neg  = rs_i[XLEN-1];
  assign zero = (rs_i == '0);

  always_comb begin
    case (kind_i)
      XK_BR_EQ:                 taken_o = eq;
      XK_BR_NE:                 taken_o = !eq;
      XK_BR_LEZ:                taken_o = neg || zero;
      XK_BR_GTZ:                taken_o = !neg && !zero;
      XK_BR_LTZ, XK_BR_LTZ_L:   taken_o = neg;
      XK_BR_GEZ, XK_BR_GEZ_L:   taken_o = !neg;
      XK_JMP, XK_JMP_L,
      XK_JMP_REG:               taken_o = 1'b1;
      default:                  taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int JT_W  = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [3:0]       kind_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [JT_W-1:0]  jt_i,
  input  logic [XLEN-1:0]  jr_i,
  output logic [XLEN-1:0]  tgt_o
);
  localparam int EXT_W = XLEN - OFF_W - 2;
  localparam int REG_W = XLEN - JT_W - 2;

  logic [XLEN-1:0] seq_pc, br_disp, br_tgt, jmp_tgt;

  assign seq_pc  = pc_i + XLEN'(4);
  assign br_disp = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign br_tgt  = seq_pc + br_disp;
  // region bits come from the transfer's own address
  assign jmp_tgt = {pc_i[XLEN-1 -: REG_W], jt_i, 2'b00};

  always_comb begin
    case (kind_i)
      XK_JMP, XK_JMP_L: tgt_o = jmp_tgt;
      XK_JMP_REG:       tgt_o = jr_i;
      default:          tgt_o = br_tgt;
    endcase
  end
endmodule

// File: rtl/npc_link.sv
module npc_link
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      kind_i,
  input  logic            act_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_o
);
  // slot is exposed, so return skips it
  assign link_o    = pc_i + XLEN'(8);
  assign link_we_o = act_i && is_link(kind_i);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          OFF_W    = 16,
  parameter int          JT_W     = 26,
  parameter logic [31:0] START_PC = 32'h0000_1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic [3:0]       xfer_kind_i,
  input  logic [OFF_W-1:0] br_off_i,
  input  logic [JT_W-1:0]  jmp_tgt_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  logic [XLEN-1:0]  jr_addr_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  link_o,
  output logic             link_we_o,
  output logic             err_o
);
  logic [XLEN-1:0] pc_q, tgt_q, tgt_d;
  logic            pend_q;
  logic            cond_taken, slot_xfer, act, take;

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind_i (xfer_kind_i),
    .rs_i   (rs_val_i),
    .rt_i   (rt_val_i),
    .taken_o(cond_taken)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W)) u_tgt (
    .pc_i  (pc_q),
    .kind_i(xfer_kind_i),
    .off_i (br_off_i),
    .jt_i  (jmp_tgt_i),
    .jr_i  (jr_addr_i),
    .tgt_o (tgt_d)
  );

  // transfer sitting in a taken transfer's slot is dropped
  assign slot_xfer = pend_q && is_xfer(xfer_kind_i);
  assign act       = !stall_i && !slot_xfer;
  assign take      = act && cond_taken;
  assign err_o     = !stall_i && slot_xfer;

  npc_link #(.XLEN(XLEN)) u_link (
    .kind_i   (xfer_kind_i),
    .act_i    (act),
    .pc_i     (pc_q),
    .link_we_o(link_we_o),
    .link_o   (link_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= XLEN'(START_PC);
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (!stall_i) begin
      pc_q   <= pend_q ? tgt_q : pc_q + XLEN'(4);
      pend_q <= take;
      if (take) tgt_q <= tgt_d;
    end
  end

  assign pc_o = pc_q;

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !pend_q) |=> (pc_o == $past(pc_o) + XLEN'(4)));

  a_r3_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(pc_o) && $stable(pend_q)));

  a_r3_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (!link_we_o && !err_o));

  a_r4_slot_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && pend_q) |=> ((pc_o == $past(tgt_q)) && !pend_q));

  a_r9_link_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_o == pc_o + XLEN'(8)));

  a_r11_err_scope: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (pend_q && !link_we_o));
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
  localparam logic [31:0] START = 32'h0000_1000;
  localparam logic [3:0] K_NONE = 4'd0, K_EQ = 4'd1, K_NE = 4'd2, K_LEZ = 4'd3,
    K_GTZ = 4'd4, K_LTZ = 4'd5, K_GEZ = 4'd6, K_LTZL = 4'd7, K_GEZL = 4'd8,
    K_J = 4'd9, K_JL = 4'd10, K_JR = 4'd11;

  logic        clk = 1'b0, rst_n = 1'b0, stall = 1'b0;
  logic [3:0]  kind = '0;
  logic [15:0] off = '0;
  logic [25:0] jt = '0;
  logic [31:0] rs = '0, rt = '0, jra = '0;
  logic [31:0] pc, lnk;
  logic        lwe, err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  npc_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .xfer_kind_i(kind),
    .br_off_i(off), .jmp_tgt_i(jt), .rs_val_i(rs), .rt_val_i(rt),
    .jr_addr_i(jra), .pc_o(pc), .link_o(lnk), .link_we_o(lwe), .err_o(err)
  );

  typedef struct {
    string       tag;
    logic [31:0] pc;
    logic        we;
    logic [31:0] link;
    logic        err;
  } exp_t;
  exp_t sb[$];

  // reference state
  logic [31:0] m_pc = START, m_tgt = '0;
  logic        m_pend = 1'b0;

  function automatic logic m_taken(input logic [3:0] k, input logic [31:0] a, b);
    case (k)
      K_EQ:           return a == b;
      K_NE:           return a != b;
      K_LEZ:          return $signed(a) <= 0;
      K_GTZ:          return $signed(a) > 0;
      K_LTZ, K_LTZL:  return $signed(a) < 0;
      K_GEZ, K_GEZL:  return $signed(a) >= 0;
      K_J, K_JL, K_JR: return 1'b1;
      default:        return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_target(input logic [3:0] k, input logic [31:0] p,
      input logic [15:0] o, input logic [25:0] t, input logic [31:0] r);
    if (k == K_J || k == K_JL) return {p[31:28], t, 2'b00};
    if (k == K_JR) return r;
    return p + 32'd4 + ($signed({{16{o[15]}}, o}) * 4);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [3:0] k, input logic [15:0] o,
      input logic [25:0] t, input logic [31:0] a, b, r, input logic st);
    exp_t e;
    logic is_x, slot, tk;
    kind = k; off = o; jt = t; rs = a; rt = b; jra = r; stall = st;
    is_x = (k >= 4'd1 && k <= 4'd11);
    slot = m_pend && is_x;
    e.tag  = tag;
    e.pc   = m_pc;
    e.we   = !st && !slot && (k == K_LTZL || k == K_GEZL || k == K_JL);
    e.link = m_pc + 32'd8;
    e.err  = !st && slot;
    sb.push_back(e);
    if (!st) begin
      tk = !slot && m_taken(k, a, b);
      if (m_pend) m_pc = m_tgt; else m_pc = m_pc + 32'd4;
      if (tk) m_tgt = m_target(k, e.pc, o, t, r);
      m_pend = tk;
    end
    @(negedge clk);
  endtask

  task automatic nop(input string tag);
    step(tag, K_NONE, '0, '0, '0, '0, '0, 1'b0);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "pc_o", pc, e.pc);
        chk(e.tag, "link_we_o", {31'd0, lwe}, {31'd0, e.we});
        if (e.we) chk(e.tag, "link_o", lnk, e.link);
        chk(e.tag, "err_o", {31'd0, err}, {31'd0, e.err});
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1", "pc_o in reset", pc, START);
    @(negedge clk);
    rst_n = 1'b1;
    nop("R1");
    nop("R2");
    step("R3", K_JL, '0, '0, '0, '0, '0, 1'b1);          // stalled link kind
    step("R5", K_EQ, 16'h0010, '0, 32'd5, 32'd5, '0, 1'b0); // 1008 -> 104C
    nop("R4");
    nop("R4");                                              // at 104C
    step("R10", K_NE, 16'h0040, '0, 32'd7, 32'd7, '0, 1'b0);
    nop("R10");
    step("R5", K_NE, 16'hFFFC, '0, 32'd1, 32'd2, '0, 1'b0); // 1054 -> 1048
    nop("R4");
    step("R6", K_LEZ, 16'h0008, '0, 32'd0, '0, '0, 1'b0);  // 1048 -> 106C
    step("R3", K_NONE, '0, '0, '0, '0, '0, 1'b1);           // stall in slot
    step("R3", K_EQ, '0, '0, '0, '0, '0, 1'b1);
    nop("R4");
    step("R6", K_GTZ, 16'h0010, '0, 32'h8000_0000, '0, '0, 1'b0);
    nop("R6");
    step("R6", K_GTZ, 16'h0010, '0, 32'd0, '0, '0, 1'b0);
    nop("R6");
    step("R6", K_LTZ, 16'h0001, '0, 32'hFFFF_FFFF, '0, '0, 1'b0);
    nop("R6");
    step("R6", K_GEZ, 16'h0002, '0, 32'd0, '0, '0, 1'b0);
    nop("R6");
    step("R9", K_LTZL, 16'h0004, '0, 32'd5, '0, '0, 1'b0);  // not taken, links
    nop("R9");
    step("R9", K_GEZL, 16'h0004, '0, 32'd5, '0, '0, 1'b0);  // taken, links
    nop("R9");
    step("R7", K_JL, '0, 26'h000_0400, '0, '0, '0, 1'b0);
    nop("R7");
    step("R7", K_J, '0, 26'h3FF_FFFF, '0, '0, '0, 1'b0);
    nop("R7");
    step("R8", K_JR, '0, '0, '0, '0, 32'h2000_0000, 1'b0);
    nop("R8");
    step("R7", K_J, '0, 26'h000_0010, '0, '0, '0, 1'b0);    // upper region kept
    nop("R7");
    step("R8", K_JR, '0, '0, '0, '0, 32'h0000_3000, 1'b0);
    step("R11", K_EQ, 16'h0100, '0, 32'd3, 32'd3, '0, 1'b0);
    nop("R11");
    nop("R11");
    step("R7", K_J, '0, 26'h000_0100, '0, '0, '0, 1'b0);
    step("R11", K_JL, '0, 26'h000_0200, '0, '0, '0, 1'b0);
    nop("R11");
    nop("R11");
    step("R12", 4'd13, 16'h0100, 26'h000_0200, 32'd3, 32'd3, 32'h5000, 1'b0);
    nop("R12");
    nop("R12");
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule